// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache that sits between a CPU load/store port and a block-oriented memory. The CPU presents a word-aligned request with a 16-bit byte address. The cache answers with a one-cycle completion strobe, a hit flag and, for loads, the addressed 32-bit word. Each of the four sets holds two lines of two 32-bit words, and each line has its own valid bit, dirty bit and 11-bit tag. Each set also keeps one bit that names its least recently used way.

On a miss the cache picks a victim way in the indexed set. If the victim holds modified data, the whole 64-bit line goes back to memory first. The cache then fetches the missing block, installs it, and replays the lookup, which now hits. Stores that hit only modify the cache line and mark it dirty. Stores that miss first bring the block in and then merge the new word. The memory side uses a request that is held until a single-cycle acknowledge arrives. Reads return the block on `memRdata` in the acknowledge cycle.

Top module: `cache2w_top`

## Requirements
- R1: The byte address is decoded as tag = bits 15..5, set = bits 4..3, word-in-line = bit 2. Bits 1..0 select a byte and do not affect which word is returned.
- R2: After reset every line is invalid, `cpuDone` and `memReq` are low, and the first access to any address misses.
- R3: A request that hits asserts `cpuDone` with `cpuHit` high in the cycle after it is accepted, and it causes no memory transaction.
- R4: Both ways of the addressed set are compared at once, and at most one way reports a match.
- R5: On a miss an invalid way is filled before any valid way is replaced, way 0 first when both are invalid, so lines already resident in the set are retained.
- R6: When both ways are valid, a miss replaces the least recently used way. Every hit and every refill makes the touched way the most recently used.
- R7: A store that hits updates only the cached word and marks the line dirty. Memory is not written at that time.
- R8: A dirty victim is written to memory as a complete line, at its own block address, before the refill read is issued. The written data includes all earlier stores to that line.
- R9: A store that misses fetches the block, merges the stored word into it and leaves the line dirty. A later load returns the stored word.
- R10: A clean victim is dropped without any memory write.
- R11: From an empty cache, loads to byte addresses 8, 0, 52, 20, 56, 16, 24, 116, 20, 8, 16 give miss, miss, miss, miss, miss, hit, miss, miss, hit, hit, hit. Address 116 displaces the block of address 52.
- R12: Once `memReq` rises it stays high, with unchanged direction, until `memAck` is seen.
- R13: A miss completes with `cpuDone` high and `cpuHit` low, and a load miss returns the refilled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Request strobe, accepted when the cache is idle |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 16 | Byte address of the request |
| cpuWdata | input | 32 | Store data |
| cpuDone | output | 1 | Request complete (one cycle) |
| cpuHit | output | 1 | Valid with cpuDone: 1 = hit, 0 = miss |
| cpuRdata | output | 32 | Load data, valid with cpuDone |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write-back of a line, 0 = block fetch |
| memAddr | output | 16 | Block-aligned byte address |
| memWdata | output | 64 | Line being written back |
| memRdata | input | 64 | Fetched block, valid with memAck |
| memAck | input | 1 | One-cycle completion of the memory transaction |

## Verification
The bench builds the cache with its default geometry: 16-bit addresses, four sets and two 32-bit words per line. With only four sets, blocks a few dozen bytes apart land in the same set. A short load sequence is therefore enough to fill both ways, exercise least-recently-used replacement and reproduce the expected hit/miss trace. The small address range also lets a memory model of 128 blocks hold every line touched. That makes it easy to force a dirty eviction and then check, in the memory image, the written-back line and the write-before-read ordering.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMP, ST_WB, ST_FILL} ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch CPU request
    logic wrWord;   // merge store word into hit line
    logic touch;    // mark hit way most recently used
    logic fill;     // install fetched block into victim way
    logic wbSel;    // memory address points at victim line
  } ctlStrobe_t;
endpackage

// File: rtl/cache2w_dpath.sv
module cache2w_dpath
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 2,
  parameter int WORD_W     = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strb,
  input  logic                           cpuWe,
  input  logic [ADDR_W-1:0]              cpuAddr,
  input  logic [WORD_W-1:0]              cpuWdata,
  output logic                           hit,
  output logic                           reqWe,
  output logic                           victimDirty,
  output logic [WORD_W-1:0]              cpuRdata,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [WORD_W*LINE_WORDS-1:0]   memWdata,
  input  logic [WORD_W*LINE_WORDS-1:0]   memRdata
);
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WORD_OFF = $clog2(LINE_WORDS);
  localparam int LOW_W    = BYTE_OFF + WORD_OFF;
  localparam int SET_W    = $clog2(NUM_SETS);
  localparam int TAG_W    = ADDR_W - SET_W - LOW_W;
  localparam int LINE_W   = WORD_W * LINE_WORDS;

  logic [TAG_W-1:0]  tagArr  [NUM_SETS][2];
  logic [LINE_W-1:0] dataArr [NUM_SETS][2];
  logic [1:0]        validArr [NUM_SETS];
  logic [1:0]        dirtyArr [NUM_SETS];
  logic [NUM_SETS-1:0] lruWay;  // per set: index of least recently used way

  logic [ADDR_W-1:0] reqAddr;
  logic [WORD_W-1:0] reqWdata;

  logic [TAG_W-1:0]    reqTag;
  logic [SET_W-1:0]    reqSet;
  logic [WORD_OFF-1:0] reqWord;
  logic [1:0]          hitVec;
  logic                hitWay;
  logic                victim;

  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet  = reqAddr[LOW_W +: SET_W];
  assign reqWord = reqAddr[BYTE_OFF +: WORD_OFF];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hitVec[w] = validArr[reqSet][w] && (tagArr[reqSet][w] == reqTag);
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  always_comb begin
    if (!validArr[reqSet][0])      victim = 1'b0;
    else if (!validArr[reqSet][1]) victim = 1'b1;
    else                           victim = lruWay[reqSet];
  end

  assign victimDirty = validArr[reqSet][victim] && dirtyArr[reqSet][victim];
  assign cpuRdata    = dataArr[reqSet][hitWay][int'(reqWord)*WORD_W +: WORD_W];
  assign memWdata    = dataArr[reqSet][victim];
  assign memAddr     = strb.wbSel ? {tagArr[reqSet][victim], reqSet, {LOW_W{1'b0}}}
                                  : {reqTag, reqSet, {LOW_W{1'b0}}};

  // request latch and per-line status bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
      lruWay   <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        validArr[s] <= '0;
        dirtyArr[s] <= '0;
      end
    end else begin
      if (strb.capture) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        reqWe    <= cpuWe;
      end
      if (strb.fill) begin
        validArr[reqSet][victim] <= 1'b1;
        dirtyArr[reqSet][victim] <= 1'b0;
        lruWay[reqSet]           <= ~victim;
      end
      if (strb.touch) lruWay[reqSet] <= ~hitWay;
      if (strb.wrWord) dirtyArr[reqSet][hitWay] <= 1'b1;
    end
  end

  // tag and data storage, no reset needed
  always_ff @(posedge clk) begin
    if (strb.fill) begin
      dataArr[reqSet][victim] <= memRdata;
      tagArr[reqSet][victim]  <= reqTag;
    end else if (strb.wrWord) begin
      dataArr[reqSet][hitWay][int'(reqWord)*WORD_W +: WORD_W] <= reqWdata;
    end
  end

  // R4: parallel compare never matches both ways
  a_r4_one_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R9: an installed block makes the replayed lookup hit
  a_r9_fill_then_hit: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |=> hit);

  // R7: a store merge only happens on a hit
  a_r7_write_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrWord |-> hit && reqWe);
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       hit,
  input  logic       reqWe,
  input  logic       victimDirty,
  input  logic       memAck,
  output ctlStrobe_t strb,
  output logic       cpuDone,
  output logic       cpuHit,
  output logic       memReq,
  output logic       memWe
);
  ctlState_t state, nextState;
  logic      missSeen;

  always_comb begin
    strb      = '0;
    nextState = state;
    cpuDone   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        strb.capture = cpuReq;
        if (cpuReq) nextState = ST_CMP;
      end
      ST_CMP: begin
        if (hit) begin
          cpuDone     = 1'b1;
          strb.wrWord = reqWe;
          strb.touch  = 1'b1;
          nextState   = ST_IDLE;
        end else begin
          nextState = victimDirty ? ST_WB : ST_FILL;
        end
      end
      ST_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        strb.wbSel = 1'b1;
        if (memAck) nextState = ST_FILL;
      end
      ST_FILL: begin
        memReq    = 1'b1;
        strb.fill = memAck;
        if (memAck) nextState = ST_CMP;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cpuHit = cpuDone && !missSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      missSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE)                 missSeen <= 1'b0;
      else if (state == ST_CMP && !hit)     missSeen <= 1'b1;
    end
  end

  // R3: completion and memory traffic never overlap
  a_r3_done_quiet_mem: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !memReq);

  // R12: request held with fixed direction until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));

  // R8: an acknowledged write-back is followed by the refill read
  a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> memReq && !memWe);

  // R10: a miss with a clean victim goes straight to the refill read
  a_r10_clean_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_CMP && !hit && !victimDirty |=> memReq && !memWe);
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_SETS   = 4,
  parameter int LINE_WORDS = 2,
  parameter int WORD_W     = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic                         cpuDone,
  output logic                         cpuHit,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         memReq,
  output logic                         memWe,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [WORD_W*LINE_WORDS-1:0] memWdata,
  input  logic [WORD_W*LINE_WORDS-1:0] memRdata,
  input  logic                         memAck
);
  ctlStrobe_t strb;
  logic       hit, reqWe, victimDirty;

  cache2w_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .hit(hit), .reqWe(reqWe),
    .victimDirty(victimDirty), .memAck(memAck), .strb(strb),
    .cpuDone(cpuDone), .cpuHit(cpuHit), .memReq(memReq), .memWe(memWe)
  );

  cache2w_dpath #(
    .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .hit(hit), .reqWe(reqWe), .victimDirty(victimDirty),
    .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );
endmodule

// File: tb/tb_cache2w_top.sv
module tb_cache2w_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        cpuDone, cpuHit;
  logic [31:0] cpuRdata;
  logic        memReq, memWe;
  logic [15:0] memAddr;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;
  logic        memAck = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cache2w_top dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int total = 0, bad = 0;
  int wbCount = 0, rdCount = 0;
  bit txnLog[$];
  logic [31:0] shw [256];   // CPU-visible word image
  logic [63:0] mem [128];   // backing store, 8-byte blocks

  typedef struct {
    bit          expHit;
    bit          chkData;
    logic [31:0] expData;
    string       req;
  } item_t;
  item_t sbq[$];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // memory model: fixed latency, one-cycle acknowledge
  initial begin
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq && rstN) begin
        repeat (2) @(negedge clk);
        txnLog.push_back(memWe);
        if (memWe) begin
          mem[memAddr[9:3]] = memWdata;
          wbCount++;
        end else begin
          memRdata = mem[memAddr[9:3]];
          rdCount++;
        end
        memAck = 1'b1;
        @(negedge clk);
        memAck = 1'b0;
      end
    end
  end

  // monitor: pop expected result on every completion
  initial begin
    forever begin
      @(negedge clk);
      if (cpuDone) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R3 unexpected completion", 64'(cpuDone), 64'd0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk(cpuHit == it.expHit, it.req, 64'(cpuHit), 64'(it.expHit));
          if (it.chkData) chk(cpuRdata == it.expData, it.req, 64'(cpuRdata), 64'(it.expData));
        end
      end
    end
  end

  // driver: push expectation, issue one request, wait for its completion
  task automatic access(bit we, logic [15:0] a, logic [31:0] d, bit expHit, string req);
    item_t it;
    it.expHit  = expHit;
    it.chkData = !we;
    it.expData = shw[a[9:2]];
    it.req     = req;
    sbq.push_back(it);
    if (we) shw[a[9:2]] = d;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuReq = 1'b0;
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wbBefore, rdBefore;
    for (int i = 0; i < 256; i++) shw[i] = 32'hC0DE_0000 | 32'(i);
    for (int b = 0; b < 128; b++) mem[b] = {shw[2*b+1], shw[2*b]};

    repeat (3) @(negedge clk);
    chk(cpuDone == 1'b0, "R2 cpuDone low in reset", 64'(cpuDone), 64'd0);
    chk(memReq == 1'b0, "R2 memReq low in reset", 64'(memReq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(memReq == 1'b0 && cpuDone == 1'b0, "R2 quiet after reset", 64'(memReq), 64'd0);

    // R11 / R2 / R6 / R13: reference trace from an empty cache
    access(0, 16'd8,   0, 0, "R11 R2 load 8 miss");
    access(0, 16'd0,   0, 0, "R11 load 0 miss");
    access(0, 16'd52,  0, 0, "R11 load 52 miss");
    access(0, 16'd20,  0, 0, "R11 load 20 miss");
    access(0, 16'd56,  0, 0, "R11 load 56 miss");
    access(0, 16'd16,  0, 1, "R11 R3 load 16 hit");
    access(0, 16'd24,  0, 0, "R11 load 24 miss");
    access(0, 16'd116, 0, 0, "R11 R6 load 116 miss evicts LRU");
    access(0, 16'd20,  0, 1, "R11 load 20 hit");
    access(0, 16'd8,   0, 1, "R11 load 8 hit");
    access(0, 16'd16,  0, 1, "R11 load 16 hit");
    access(0, 16'd52,  0, 0, "R6 load 52 was displaced by 116");
    chk(wbCount == 0, "R10 clean evictions write nothing", 64'(wbCount), 64'd0);

    // R9 / R5: store miss into set 0 fills the free way, keeps address 0
    access(1, 16'h0104, 32'h1111_2222, 0, "R9 store miss allocates");
    access(0, 16'h0000, 0, 1, "R5 resident line kept on fill");
    access(0, 16'h0104, 0, 1, "R9 merged word reads back");

    // R7: store hit touches cache only
    wbBefore = wbCount; rdBefore = rdCount;
    access(1, 16'h0100, 32'h3333_4444, 1, "R7 store hit");
    chk(wbCount == wbBefore && rdCount == rdBefore, "R7 no memory traffic on store hit",
        64'(wbCount + rdCount), 64'(wbBefore + rdBefore));
    chk(mem[32] == 64'hC0DE_0041_C0DE_0040, "R7 memory copy unchanged", mem[32],
        64'hC0DE_0041_C0DE_0040);
    access(0, 16'h0000, 0, 1, "R6 touch way 0, dirty line becomes LRU");

    // R8: dirty victim written back whole, before the refill read
    wbBefore = wbCount;
    access(0, 16'h0200, 0, 0, "R8 R13 load miss evicting dirty line");
    chk(wbCount == wbBefore + 1, "R8 one write-back", 64'(wbCount), 64'(wbBefore + 1));
    chk(mem[32] == {shw[65], shw[64]}, "R8 written line content", mem[32], {shw[65], shw[64]});
    chk(txnLog.size() >= 2 && txnLog[txnLog.size()-2] == 1'b1 && txnLog[txnLog.size()-1] == 1'b0,
        "R8 write-back precedes refill", 64'(txnLog.size()), 64'd2);

    // R10: clean victim (address 0) replaced silently; refill returns stored word
    wbBefore = wbCount;
    access(0, 16'h0104, 0, 0, "R8 R13 refetch of written-back word");
    chk(wbCount == wbBefore, "R10 no write for clean victim", 64'(wbCount), 64'(wbBefore));

    // R1: byte offset bits do not change the selected word
    access(0, 16'h0107, 0, 1, "R1 byte offset ignored");
    access(0, 16'h0203, 0, 1, "R1 word 0 via unaligned byte");
    access(0, 16'h0100, 0, 1, "R1 word bit selects other word");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule